// File: doc/BRIEF.md
# Channel-Tagged Host/Remote Mailbox

This block carries 32-bit messages in both directions between a host processor and a remote agent. The host reaches it through a small word-addressed register window with separate read and write strobes. Words the host writes to the send register go into an outbound queue. The remote agent takes them from that queue over a valid/ready port. The remote agent pushes words into an inbound queue over a second valid/ready port. The host removes them by reading the receive register. It can also inspect the oldest word through a separate peek register that leaves the queue unchanged.

The low nibble of every word is a channel tag and the upper 28 bits are the payload. The mailbox stores and forwards each word unchanged and in arrival order, whatever its channel. The host sorts out which channel a word belongs to. It polls a status register that shows whether the outbound queue is full, whether the inbound queue is empty, and how many inbound words are waiting. A control register holds an interrupt enable and a sticky flag that records a send the block dropped.

Top module: `tagged_mailbox`

## Requirements
- R1: A word keeps all 32 bits unchanged on its way through either queue. This includes the channel tag in bits [3:0] and the payload in bits [31:4].
- R2: The host register map uses word addresses 0 (receive, pops), 2 (peek), 4 (control), 6 (status) and 8 (send). `host_rdata` is loaded on the clock edge where `host_rd` is high and holds between reads. Reads of any other address return zero. Host writes to addresses other than 4 and 8 change nothing.
- R3: Status bit 31 is 1 exactly when the outbound queue holds DEPTH words. This is judged on the occupancy before the edge, even if the remote side drains a word in that same cycle. A send while bit 31 is 1 is discarded and sets control bit 1 (overflow).
- R4: Status bit 30 is 1 exactly when the inbound queue is empty. Status bits [7:0] give the inbound occupancy, and all other status bits read zero.
- R5: A read of the receive register returns the oldest inbound word and removes it. Words come out in arrival order regardless of their channel tag.
- R6: A read of the peek register returns the oldest inbound word and does not remove it.
- R7: A receive or peek read while the inbound queue is empty returns zero and leaves the queues unchanged.
- R8: Control bit 0 is a read/write interrupt enable. `irq` is high exactly when the enable is set and the inbound queue is not empty.
- R9: Control bit 1 (overflow) stays set until the host writes control with bit 1 = 1. Writing control with bit 1 = 0 leaves it unchanged.
- R10: `out_valid` is high whenever the outbound queue is non-empty. A word transfers on an edge with `out_valid` and `out_ready` both high. Words leave in send order, and `out_data` holds steady while the transfer is stalled.
- R11: `in_ready` is low exactly when the inbound queue holds DEPTH words. A word offered while `in_ready` is low is not stored.
- R12: After reset both queues are empty, status reads 0x4000_0000, control reads zero, and `irq` and `out_valid` are low.
- R13: A remote push and a host pop of the inbound queue in the same cycle both take effect, and so do a host send and a remote drain of the outbound queue, leaving the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| out_valid | output | 1 | Outbound word available |
| out_ready | input | 1 | Remote accepts outbound word |
| out_data | output | 32 | Oldest outbound word |
| in_valid | input | 1 | Remote offers an inbound word |
| in_ready | output | 1 | Inbound queue can take a word |
| in_data | input | 32 | Inbound word |
| irq | output | 1 | Inbound data interrupt |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a host pop of the receive register and a remote push into the inbound queue. The second is a host send and a remote drain of the outbound queue. The bench provokes the inbound pair by reading and pushing in one cycle, once with the queue partly filled and once with it full. It provokes the outbound pair by filling the queue with the drain held off, then releasing the drain in the same cycle as another send. A scoreboard judges each case: it predicts the returned word, the surviving occupancy and whether the send is dropped, then checks the status register, the overflow flag and the order in which the drained words appear.

// File: rtl/tagged_mailbox.sv
module tagged_mailbox #(
  parameter int DEPTH = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_RECV = AW'(0);
  localparam logic [AW-1:0] A_PEEK = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(6);
  localparam logic [AW-1:0] A_SEND = AW'(8);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [31:0]   ob_mem [DEPTH];
  logic [31:0]   ib_mem [DEPTH];
  logic [PW-1:0] ob_rp, ob_wp, ib_rp, ib_wp;
  logic [CW-1:0] ob_cnt, ib_cnt;
  logic          ien, ovf;
  logic [31:0]   rd_sel;

  wire ob_full  = (ob_cnt == CW'(DEPTH));
  wire ib_empty = (ib_cnt == '0);
  wire send_hit = host_wr && (host_addr == A_SEND);
  wire ctrl_hit = host_wr && (host_addr == A_CTRL);
  wire ob_push  = send_hit && !ob_full;
  wire ob_pop   = out_valid && out_ready;
  wire ib_push  = in_valid && in_ready;
  wire ib_pop   = host_rd && (host_addr == A_RECV) && !ib_empty;

  assign out_valid = (ob_cnt != '0);
  assign out_data  = ob_mem[ob_rp];
  assign in_ready  = (ib_cnt != CW'(DEPTH));
  assign irq       = ien && !ib_empty;

  always_ff @(posedge clk) begin
    if (ob_push) ob_mem[ob_wp] <= host_wdata;
    if (ib_push) ib_mem[ib_wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_rp <= '0; ob_wp <= '0; ob_cnt <= '0;
      ib_rp <= '0; ib_wp <= '0; ib_cnt <= '0;
    end else begin
      if (ob_push) ob_wp <= step(ob_wp);
      if (ob_pop)  ob_rp <= step(ob_rp);
      if (ib_push) ib_wp <= step(ib_wp);
      if (ib_pop)  ib_rp <= step(ib_rp);
      ob_cnt <= ob_cnt + CW'(ob_push) - CW'(ob_pop);
      ib_cnt <= ib_cnt + CW'(ib_push) - CW'(ib_pop);
    end
  end

  always_comb begin
    case (host_addr)
      A_RECV, A_PEEK: rd_sel = ib_empty ? '0 : ib_mem[ib_rp];
      A_CTRL:         rd_sel = {30'd0, ovf, ien};
      A_STAT:         rd_sel = {ob_full, ib_empty, 22'd0, 8'(ib_cnt)};
      default:        rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      ien        <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rd_sel;
      if (ctrl_hit) ien <= host_wdata[0];
      if (send_hit && ob_full) ovf <= 1'b1;
      else if (ctrl_hit && host_wdata[1]) ovf <= 1'b0;
    end
  end

  p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_hit && ob_full |=> ovf);
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_hit && ob_full && !out_ready |=> ob_cnt == CW'(DEPTH));
  p_peek_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == A_PEEK && !in_valid |=> $stable(ib_cnt));
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == A_RECV && ib_empty |=> host_rdata == '0);
  p_irq_on_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ien && ib_push && !ctrl_hit |=> irq);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(ctrl_hit && host_wdata[1]) |=> ovf);
  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_full_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !ib_pop |=> $stable(ib_cnt));
  p_bounds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ob_cnt <= CW'(DEPTH) && ib_cnt <= CW'(DEPTH));
endmodule

// File: tb/tagged_mailbox_bench.sv
`timescale 1ns/1ps
module tagged_mailbox_bench;
  localparam int DEPTH = 8;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_rd = 0, host_wr = 0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, in_data = '0;
  logic [31:0] host_rdata, out_data;
  logic out_valid, out_ready = 0, in_valid = 0, in_ready, irq;

  tagged_mailbox #(.DEPTH(DEPTH), .AW(AW)) u_tagged_mailbox (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] ob_q[$];
  logic [31:0] ib_q[$];
  bit m_ien = 0, m_ovf = 0;
  int ready_mode = 0;
  bit tog = 0, drain_now = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 0; drain_now = 0;
    end else begin
      if (out_valid !== (ob_q.size() != 0)) begin
        errors++;
        $display("FAIL R10 out_valid actual %b expected %b", out_valid, ob_q.size() != 0);
      end
      case (ready_mode)
        0: out_ready = 0;
        1: out_ready = 1;
        default: begin out_ready = tog; tog = ~tog; end
      endcase
      drain_now = out_ready && out_valid;
      if (drain_now && ob_q.size() != 0) begin
        chk("R10 R1 drained word", out_data, ob_q[0]);
        void'(ob_q.pop_front());
      end
    end
  end

  task automatic cyc(input bit rd, input bit wr, input int a, input logic [31:0] wd,
                     input bit pv, input logic [31:0] pd, input string req);
    logic [31:0] exp;
    int ob_lvl;
    bit acc_in;
    @(negedge clk); #1;
    host_rd = rd; host_wr = wr; host_addr = AW'(a); host_wdata = wd;
    in_valid = pv; in_data = pd;
    ob_lvl = ob_q.size() + int'(drain_now);
    exp = '0;
    case (a)
      0, 2: exp = (ib_q.size() != 0) ? ib_q[0] : 32'h0;
      4: exp = {30'd0, m_ovf, m_ien};
      6: exp = {ob_lvl == DEPTH, ib_q.size() == 0, 22'd0, 8'(ib_q.size())};
      default: exp = '0;
    endcase
    acc_in = ib_q.size() < DEPTH;
    if (pv) chk("R11 in_ready", in_ready, acc_in);
    if (wr && a == 8) begin
      if (ob_lvl < DEPTH) ob_q.push_back(wd); else m_ovf = 1;
    end
    if (wr && a == 4) begin
      m_ien = wd[0];
      if (wd[1]) m_ovf = 0;
    end
    if (rd && a == 0 && ib_q.size() != 0) void'(ib_q.pop_front());
    if (pv && acc_in) ib_q.push_back(pd);
    @(negedge clk); #1;
    host_rd = 0; host_wr = 0; in_valid = 0;
    if (rd) chk(req, host_rdata, exp);
  endtask

  task automatic rd_reg(input int a, input string req);
    cyc(1, 0, a, 0, 0, 0, req);
  endtask
  task automatic wr_reg(input int a, input logic [31:0] d);
    cyc(0, 1, a, d, 0, 0, "");
  endtask
  task automatic push(input logic [31:0] d);
    cyc(0, 0, 0, 0, 1, d, "R11 push");
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R12 out_valid", out_valid, 0);
    chk("R12 irq", irq, 0);
    chk("R12 in_ready", in_ready, 1);
    rd_reg(6, "R12 R4 status after reset");
    chk("R12 status literal", host_rdata, 32'h4000_0000);
    rd_reg(4, "R12 control after reset");

    push(32'h1234_5670); push(32'hABCD_EF01); push(32'h0000_0129);
    rd_reg(6, "R4 status count 3");
    chk("R4 status literal", host_rdata, 32'h0000_0003);
    rd_reg(2, "R6 peek first");
    rd_reg(2, "R6 peek repeat");
    rd_reg(0, "R5 R1 read channel 0");
    rd_reg(0, "R5 R1 read channel 1");
    rd_reg(0, "R5 R1 read channel 9");
    rd_reg(0, "R7 read empty");
    rd_reg(2, "R7 peek empty");
    rd_reg(6, "R7 status still empty");

    ready_mode = 0;
    for (int i = 0; i < DEPTH; i++) wr_reg(8, 32'hC0DE_0000 | (i << 4) | (i % 16));
    rd_reg(6, "R3 status full");
    chk("R3 full bit", host_rdata[31], 1);
    wr_reg(8, 32'hDEAD_BEE8);
    rd_reg(4, "R3 overflow flag set");
    chk("R3 overflow literal", host_rdata, 32'h2);
    wr_reg(4, 32'h0);
    rd_reg(4, "R9 overflow survives zero write");
    wr_reg(4, 32'h2);
    rd_reg(4, "R9 overflow cleared");
    ready_mode = 2;
    repeat (40) @(negedge clk);
    chk("R10 outbound drained", ob_q.size(), 0);

    ready_mode = 0;
    for (int i = 0; i < DEPTH; i++) wr_reg(8, 32'h5500_0008 + (i << 8));
    ready_mode = 1;
    wr_reg(8, 32'h7777_7771);
    rd_reg(4, "R13 R3 send dropped while draining full");
    repeat (20) @(negedge clk);
    chk("R13 drained after concurrent send", out_valid, 0);
    for (int i = 0; i < 6; i++) wr_reg(8, 32'h6600_0000 + i);
    repeat (10) @(negedge clk);
    rd_reg(4, "R13 streaming send no overflow");
    ready_mode = 0;

    wr_reg(4, 32'h1);
    @(negedge clk); #1;
    chk("R8 irq low when empty", irq, 0);
    for (int i = 0; i < DEPTH; i++) push(32'hA000_0000 + (i << 4) + (i % 10));
    @(negedge clk); #1;
    chk("R8 irq high", irq, 1);
    chk("R11 in_ready low when full", in_ready, 0);
    push(32'hFFFF_FFFF);
    rd_reg(6, "R11 R4 status full count");
    cyc(1, 0, 0, 0, 1, 32'hBBBB_BBB2, "R13 pop with push while full");
    rd_reg(6, "R13 count after full pop");
    cyc(1, 0, 0, 0, 1, 32'hCCCC_CCC3, "R13 pop with push");
    rd_reg(6, "R13 count unchanged");
    for (int i = 0; i < DEPTH; i++) rd_reg(0, "R5 drain inbound order");
    @(negedge clk); #1;
    chk("R8 irq low after drain", irq, 0);
    push(32'h0000_0010);
    wr_reg(4, 32'h0);
    @(negedge clk); #1;
    chk("R8 irq masked", irq, 0);

    wr_reg(1, 32'hFFFF_FFFF);
    wr_reg(0, 32'hFFFF_FFFF);
    wr_reg(6, 32'hFFFF_FFFF);
    rd_reg(4, "R2 control unchanged by stray writes");
    rd_reg(6, "R2 status unchanged by stray writes");
    rd_reg(1, "R2 unmapped read");
    rd_reg(3, "R2 unmapped read");
    rd_reg(8, "R2 send register reads zero");
    rd_reg(0, "R2 R5 word survives stray writes");
    chk("R2 outbound untouched", out_valid, 0);
    summary();
  end
endmodule